// File: doc/BRIEF.md
# Sustained Overrange Flag Generator

This block watches the conversion results of an audio converter, one lane per channel, and raises a sticky warning flag when a channel clips. Each conversion arrives as a one-cycle valid strobe carrying a single bit that says whether the sample went past full scale. Detecting that condition from raw data happens upstream.

A lone clipped sample is tolerated. The flag for a channel goes high only when two of that channel's accepted conversions in a row are both out of range. Once high, the flag stays up for a fixed number of frame periods. A frame period is one cycle of the left/right word clock, and upstream marks each one with a single-cycle tick.

An active-low power-down forces every flag low and wipes all history and timing state. The channel count is a parameter, so the default stereo build gives the left and right lanes their own independent flags.

Top module: `sat_flag_stretch`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every `ovr_flag` bit is 0. Reset also clears the remembered state of the previous conversion.
- R2: When a channel accepts a conversion (`smp_valid`=1) with `smp_over`=1, and that channel's previous accepted conversion also had `smp_over`=1, the channel's flag is 1 from the next clock edge on. The first conversion after reset or power-down has no predecessor.
- R3: An accepted conversion with `smp_over`=0 breaks the chain. The next overrange conversion after it never raises the flag by itself.
- R4: While `smp_valid`=0, the value of `smp_over` is ignored. Cycles without a strobe neither break nor extend the chain of consecutive conversions.
- R5: Once raised, a flag stays 1 for exactly `HOLD_PERIODS` frame ticks. It drops to 0 at the clock edge that takes the `HOLD_PERIODS`-th tick after the last trigger, and it never falls on a cycle without a tick.
- R6: A new qualifying pair while the flag is high restarts the hold count from the beginning. A trigger in the same cycle as a tick also restarts, and that tick is not counted.
- R7: Each channel's flag depends only on its own `smp_valid`/`smp_over` bits. The channels share only `frame_tick`, `pd_n` and `rst`.
- R8: While `pd_n`=0, every flag is 0 from the next edge on, and all strobes are ignored. After `pd_n` returns to 1, the flag rises only on a fresh pair of overrange conversions that are both accepted after the release.
- R9: The pair check slides. In a run of three or more overrange conversions, each conversion after the first counts as a new pair and restarts the hold count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Active-low digital power-down |
| frame_tick | input | 1 | One-cycle pulse per left/right frame period |
| smp_valid | input | NUM_CH | Per-channel conversion strobe |
| smp_over | input | NUM_CH | Per-channel "sample beyond full scale" bit, qualified by `smp_valid` |
| ovr_flag | output | NUM_CH | Per-channel registered sustained-overrange flag |

## Verification
The bench builds two copies of the block side by side and drives both with the same two-channel stimulus. One copy keeps the default hold of 4096 frame periods, so the exact expiry edge is checked at full length. The other uses a hold of 5, which brings frequent expiry, retriggers during an active hold, trigger-on-tick collisions and sliding runs within reach of a short random run. Random power-down pulses check that history is erased at many different points in the chain and the hold.

// File: rtl/sat_flag_pkg.sv
package sat_flag_pkg;
  localparam int DEF_NUM_CH = 2;
  localparam int DEF_HOLD_PERIODS = 4096;

  // Width of a down-counter that must represent HOLD-1 .. 0
  function automatic int hold_cnt_w(input int periods);
    return (periods <= 2) ? 1 : $clog2(periods);
  endfunction
endpackage

// File: rtl/sat_pair_detect.sv
module sat_pair_detect (
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  input  logic smp_valid,
  input  logic smp_over,
  output logic pair_hit
);
  logic prev_over;

  always_ff @(posedge clk) begin
    if (rst || !pd_n)
      prev_over <= 1'b0;
    else if (smp_valid)
      prev_over <= smp_over;
  end

  assign pair_hit = pd_n & smp_valid & smp_over & prev_over;
endmodule

// File: rtl/sat_hold_timer.sv
module sat_hold_timer #(
  parameter int HOLD_PERIODS = sat_flag_pkg::DEF_HOLD_PERIODS,
  parameter int CNT_W        = sat_flag_pkg::hold_cnt_w(HOLD_PERIODS)
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  input  logic restart,
  input  logic frame_tick,
  output logic flag
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_PERIODS - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || !pd_n) begin
      flag   <= 1'b0;
      remain <= '0;
    end else if (restart) begin
      flag   <= 1'b1;
      remain <= LOAD_VAL;
    end else if (flag && frame_tick) begin
      if (remain == '0)
        flag <= 1'b0;
      else
        remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/sat_flag_stretch.sv
module sat_flag_stretch #(
  parameter int NUM_CH       = sat_flag_pkg::DEF_NUM_CH,
  parameter int HOLD_PERIODS = sat_flag_pkg::DEF_HOLD_PERIODS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_n,
  input  logic              frame_tick,
  input  logic [NUM_CH-1:0] smp_valid,
  input  logic [NUM_CH-1:0] smp_over,
  output logic [NUM_CH-1:0] ovr_flag
);
  localparam int CNT_W = sat_flag_pkg::hold_cnt_w(HOLD_PERIODS);

  logic [NUM_CH-1:0] pair_hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    sat_pair_detect u_detect (
      .clk       (clk),
      .rst       (rst),
      .pd_n      (pd_n),
      .smp_valid (smp_valid[c]),
      .smp_over  (smp_over[c]),
      .pair_hit  (pair_hit[c])
    );

    sat_hold_timer #(
      .HOLD_PERIODS (HOLD_PERIODS),
      .CNT_W        (CNT_W)
    ) u_timer (
      .clk        (clk),
      .rst        (rst),
      .pd_n       (pd_n),
      .restart    (pair_hit[c]),
      .frame_tick (frame_tick),
      .flag       (ovr_flag[c])
    );
  end
endmodule

// File: rtl/sat_flag_checker.sv
module sat_flag_checker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              pd_n,
  input logic              frame_tick,
  input logic [NUM_CH-1:0] smp_valid,
  input logic [NUM_CH-1:0] smp_over,
  input logic [NUM_CH-1:0] ovr_flag
);
  // Checker-side record of the last accepted conversion per channel
  logic [NUM_CH-1:0] seen_over;

  always_ff @(posedge clk) begin
    if (rst || !pd_n)
      seen_over <= '0;
    else
      for (int i = 0; i < NUM_CH; i++)
        if (smp_valid[i]) seen_over[i] <= smp_over[i];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2 / R7: a rise needs an overrange conversion on this very channel
    a_r2_rise_needs_own_over: assert property (@(posedge clk) disable iff (rst)
      $rose(ovr_flag[c]) |-> $past(pd_n && smp_valid[c] && smp_over[c]));

    // R2 / R9: every consecutive overrange pair leaves the flag high
    a_r2_pair_sets_flag: assert property (@(posedge clk) disable iff (rst)
      (pd_n && smp_valid[c] && smp_over[c] && seen_over[c]) |=> ovr_flag[c]);

    // R8: power-down forces the flag low
    a_r8_pd_forces_low: assert property (@(posedge clk) disable iff (rst)
      !pd_n |=> !ovr_flag[c]);

    // R5: the flag only ends on a frame tick (or power-down)
    a_r5_fall_on_tick: assert property (@(posedge clk) disable iff (rst)
      $fell(ovr_flag[c]) |-> $past(frame_tick || !pd_n));

    // R5: without a tick the flag holds
    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
      (ovr_flag[c] && pd_n && !frame_tick) |=> ovr_flag[c]);
  end
endmodule

bind sat_flag_stretch sat_flag_checker #(.NUM_CH(NUM_CH)) u_sat_flag_checker (
  .clk        (clk),
  .rst        (rst),
  .pd_n       (pd_n),
  .frame_tick (frame_tick),
  .smp_valid  (smp_valid),
  .smp_over   (smp_over),
  .ovr_flag   (ovr_flag)
);

// File: tb/sat_flag_stretch_bench.sv
`timescale 1ns/1ps
module sat_flag_stretch_bench;
  localparam int NCH      = 2;
  localparam int HOLD_L   = 4096;
  localparam int HOLD_S   = 5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           pd_n = 1'b1;
  logic           frame_tick = 1'b0;
  logic [NCH-1:0] smp_valid = '0;
  logic [NCH-1:0] smp_over = '0;
  logic [NCH-1:0] flag_l, flag_s;

  always #5 clk = ~clk;

  sat_flag_stretch #(.NUM_CH(NCH), .HOLD_PERIODS(HOLD_L)) u_sat_flag_stretch (
    .clk(clk), .rst(rst), .pd_n(pd_n), .frame_tick(frame_tick),
    .smp_valid(smp_valid), .smp_over(smp_over), .ovr_flag(flag_l));

  sat_flag_stretch #(.NUM_CH(NCH), .HOLD_PERIODS(HOLD_S)) u_sat_flag_stretch_short (
    .clk(clk), .rst(rst), .pd_n(pd_n), .frame_tick(frame_tick),
    .smp_valid(smp_valid), .smp_over(smp_over), .ovr_flag(flag_s));

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";

  // Reference state: remaining ticks per (copy, channel) and last accepted bit
  int rem_m [2][NCH];
  bit prev_m [NCH];

  function automatic int hold_of(input int k);
    return (k == 0) ? HOLD_L : HOLD_S;
  endfunction

  function automatic bit exp_flag(input int k, input int c);
    return rem_m[k][c] > 0;
  endfunction

  task automatic model_step();
    if (rst || !pd_n) begin
      for (int c = 0; c < NCH; c++) begin
        prev_m[c] = 1'b0;
        for (int k = 0; k < 2; k++) rem_m[k][c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit hit = smp_valid[c] && smp_over[c] && prev_m[c];
        if (smp_valid[c]) prev_m[c] = smp_over[c];
        for (int k = 0; k < 2; k++) begin
          if (hit) rem_m[k][c] = hold_of(k);
          else if (frame_tick && rem_m[k][c] > 0) rem_m[k][c] = rem_m[k][c] - 1;
        end
      end
    end
  endtask

  task automatic compare();
    for (int k = 0; k < 2; k++)
      for (int c = 0; c < NCH; c++) begin
        logic act = (k == 0) ? flag_l[c] : flag_s[c];
        n_checks++;
        if (act !== exp_flag(k, c)) begin
          n_fail++;
          $display("FAIL %s copy%0d ch%0d t=%0t: flag=%0b expected=%0b",
                   cur_req, k, c, $time, act, exp_flag(k, c));
        end
      end
  endtask

  // Apply inputs (already set after a negedge), take one edge, then check
  task automatic step(input logic [NCH-1:0] v, input logic [NCH-1:0] o,
                      input logic t, input logic p);
    smp_valid = v; smp_over = o; frame_tick = t; pd_n = p;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n, input logic t);
    for (int i = 0; i < n; i++) step('0, '0, t, 1'b1);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      prev_m[c] = 0;
      for (int k = 0; k < 2; k++) rem_m[k][c] = 0;
    end
    void'($urandom(32'd7531));
    @(negedge clk);
    // R1: reset state, overrange strobes during reset ignored
    cur_req = "R1";
    for (int i = 0; i < 4; i++) step(2'b11, 2'b11, 1'b1, 1'b1);
    rst = 1'b0;
    step('0, '0, 1'b0, 1'b1);

    // R2: two back-to-back overrange on ch0 only (R7: ch1 stays low)
    cur_req = "R2";
    step(2'b01, 2'b01, 1'b0, 1'b1);
    step(2'b01, 2'b01, 1'b0, 1'b1);
    cur_req = "R7";
    idle(3, 1'b0);

    // R3: in-range between overrange on ch1
    cur_req = "R3";
    step(2'b10, 2'b10, 1'b0, 1'b1);
    step(2'b10, 2'b00, 1'b0, 1'b1);
    step(2'b10, 2'b10, 1'b0, 1'b1);
    idle(2, 1'b0);

    // R8: power-down clears all; released history is empty
    cur_req = "R8";
    step(2'b11, 2'b11, 1'b0, 1'b0);
    step('0, '0, 1'b0, 1'b1);
    step(2'b11, 2'b11, 1'b0, 1'b1);
    idle(2, 1'b0);

    // R4: gaps with over asserted but no strobe keep the chain
    cur_req = "R4";
    step(2'b00, 2'b11, 1'b0, 1'b1);
    step(2'b00, 2'b11, 1'b0, 1'b1);
    step(2'b10, 2'b10, 1'b0, 1'b1);
    step(2'b00, 2'b00, 1'b0, 1'b1);

    // R5: full-length expiry with a tick every cycle
    cur_req = "R5";
    step('0, '0, 1'b0, 1'b0);
    step(2'b01, 2'b01, 1'b0, 1'b1);
    step(2'b01, 2'b01, 1'b0, 1'b1);
    idle(HOLD_L + 3, 1'b1);

    // R6: retrigger while high; trigger coincident with tick
    cur_req = "R6";
    step(2'b01, 2'b01, 1'b0, 1'b1);
    step(2'b01, 2'b01, 1'b0, 1'b1);
    idle(3, 1'b1);
    step(2'b01, 2'b01, 1'b1, 1'b1);
    idle(HOLD_S + 2, 1'b1);

    // R9: a run of overrange conversions keeps restarting the hold
    cur_req = "R9";
    for (int i = 0; i < 6; i++) begin
      step(2'b10, 2'b10, 1'b1, 1'b1);
      idle(2, 1'b1);
    end
    idle(HOLD_S + 2, 1'b1);

    // Random mixture over all requirements
    cur_req = "R2-random";
    for (int i = 0; i < 30000; i++) begin
      logic [NCH-1:0] v, o;
      for (int c = 0; c < NCH; c++) begin
        v[c] = ($urandom % 3) == 0;
        o[c] = ($urandom % 2) == 0;
      end
      step(v, o, ($urandom % 4) == 0, ($urandom % 200) != 0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule